// File: doc/BRIEF.md
# Nonvolatile Array Write Protection Gate

This block stands between a CPU-side write port and a 256-byte nonvolatile data array. Every write or erase request is judged in the cycle it arrives. It passes to the array as a single-cycle program strobe, registered together with its address, data and operation, only when all of these hold:

- the block is out of reset,
- the device is not in a low-power state,
- the target region is unprotected, or the high-voltage override input is asserted.

A refused request raises a sticky violation flag that software clears by writing a one to it.

The array is divided into equal regions of 32 bytes, and each region has one bit in a protection mask. After reset the gate is in privileged mode, and the mask can be loaded freely. Writing a one to the lock input moves the gate into nonprivileged mode. From then on, mask writes are ignored. The lock cannot be undone by software; only a reset clears it. The current mask and lock state are brought out so that software can read them back.

Top module: `nvwp_gate`

## Requirements
- R1: The region of a request is address bits [7:5], so mask bit i covers addresses 32*i through 32*i+31 (eight regions).
- R2: A request to a region whose mask bit is 1 is refused unless hv_override is 1 in the request cycle; a request to a region whose bit is 0 is accepted.
- R3: For an accepted request, pgm_stb is 1 in the cycle after the request edge, with pgm_addr, pgm_data and pgm_erase (1 = erase, 0 = write) holding the request values. pgm_stb is 1 for exactly one cycle for each request cycle, and 0 when no request was accepted.
- R4: Any request made while lowpwr is 1 is refused, whatever the mask and override.
- R5: While rst is 1 no request is accepted. A synchronous reset sets prot_q to 0, locked_q to 0, viol to 0 and pgm_stb to 0.
- R6: In privileged mode (locked_q = 0), prot_we loads prot_wdata into prot_q one cycle later.
- R7: lock_we with lock_wdata = 1 sets locked_q one cycle later. While locked_q is 1, prot_we has no effect on prot_q, but the mask is still enforced.
- R8: lock_we with lock_wdata = 0 has no effect; only reset returns locked_q to 0.
- R9: A refused request sets viol one cycle later, and viol stays set until viol_clr is 1. If a refusal and viol_clr fall in the same cycle, viol ends up 1.
- R10: A request is judged against the mask and lock state held before that edge. A mask write in the same cycle as a request affects only later requests, and a mask write in the same cycle as the lock write is still taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write/erase request, one per cycle held |
| wr_addr | input | 8 | Byte address of the request |
| wr_data | input | 8 | Data to program |
| wr_erase | input | 1 | 1 = erase, 0 = write |
| prot_we | input | 1 | Load the protection mask |
| prot_wdata | input | 8 | New protection mask, bit i for region i |
| lock_we | input | 1 | Write to the privilege lock |
| lock_wdata | input | 1 | Value written to the lock (only 1 acts) |
| viol_clr | input | 1 | Write-one-to-clear for the violation flag |
| lowpwr | input | 1 | Device is in a low-power state |
| hv_override | input | 1 | External override of region protection |
| pgm_stb | output | 1 | Qualified program strobe to the array |
| pgm_addr | output | 8 | Address registered with the strobe |
| pgm_data | output | 8 | Data registered with the strobe |
| pgm_erase | output | 1 | Operation registered with the strobe |
| viol | output | 1 | Sticky violation flag |
| prot_q | output | 8 | Current protection mask |
| locked_q | output | 1 | 1 = nonprivileged (locked) mode |

## Verification
Every result is due one clock after the edge that samples its cause. The strobe and its address, data and operation, the violation flag, the mask and the lock all change at that edge. The strobe must be low again one further cycle later.

The bench drives its inputs on the falling edge, holds a request for one cycle, and samples on the next falling edge. It then samples once more to confirm the strobe has dropped. Array contents are compared after each sweep, using a bench array written on the strobe against a model the bench keeps from the rules.

// File: rtl/nvwp_pkg.sv
package nvwp_pkg;

  // Outcome of the qualification stage for one cycle.
  typedef enum logic [1:0] {
    DEC_IDLE   = 2'd0,   // no request
    DEC_PASS   = 2'd1,   // request forwarded to the array
    DEC_GUARD  = 2'd2,   // refused: region protected
    DEC_SLEEP  = 2'd3    // refused: low-power state
  } nv_dec_e;

  function automatic logic dec_refused(input nv_dec_e d);
    return (d == DEC_GUARD) || (d == DEC_SLEEP);
  endfunction

endpackage

// File: rtl/nvwp_cfg.sv
module nvwp_cfg #(
  parameter int NUM_BLK = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prot_we,
  input  logic [NUM_BLK-1:0] prot_wdata,
  input  logic               lock_we,
  input  logic               lock_wdata,
  output logic [NUM_BLK-1:0] prot_q,
  output logic               locked_q
);

  // Mask register: writable only while the lock is open (old lock value).
  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q <= '0;
    end else if (prot_we && !locked_q) begin
      prot_q <= prot_wdata;
    end
  end

  // One-way lock: software may set it, only reset clears it.
  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
    end else if (lock_we && lock_wdata) begin
      locked_q <= 1'b1;
    end
  end

endmodule

// File: rtl/nvwp_qual.sv
module nvwp_qual
  import nvwp_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BLK_W   = 5,
  parameter int NUM_BLK = 2 ** (ADDR_W - BLK_W)
) (
  input  logic               rst,
  input  logic               wr_req,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [NUM_BLK-1:0] prot_q,
  input  logic               lowpwr,
  input  logic               hv_override,
  output nv_dec_e            dec
);

  localparam int IDX_W = ADDR_W - BLK_W;

  logic [IDX_W-1:0]   region;
  logic [NUM_BLK-1:0] hit;
  logic               guarded;

  assign region = wr_addr[ADDR_W-1:BLK_W];

  // One-hot region decode, one comparator per region.
  for (genvar i = 0; i < NUM_BLK; i++) begin : g_region
    assign hit[i] = (region == IDX_W'(i));
  end

  assign guarded = |(hit & prot_q);

  always_comb begin
    if (rst || !wr_req) begin
      dec = DEC_IDLE;
    end else if (lowpwr) begin
      dec = DEC_SLEEP;
    end else if (guarded && !hv_override) begin
      dec = DEC_GUARD;
    end else begin
      dec = DEC_PASS;
    end
  end

endmodule

// File: rtl/nvwp_out.sv
module nvwp_out
  import nvwp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  nv_dec_e           dec,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_erase,
  input  logic              viol_clr,
  output logic              pgm_stb,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [DATA_W-1:0] pgm_data,
  output logic              pgm_erase,
  output logic              viol
);

  // Strobe and its payload, registered together.
  always_ff @(posedge clk) begin
    if (rst) begin
      pgm_stb   <= 1'b0;
      pgm_addr  <= '0;
      pgm_data  <= '0;
      pgm_erase <= 1'b0;
    end else begin
      pgm_stb <= (dec == DEC_PASS);
      if (dec == DEC_PASS) begin
        pgm_addr  <= wr_addr;
        pgm_data  <= wr_data;
        pgm_erase <= wr_erase;
      end
    end
  end

  // Sticky flag, a new refusal wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      viol <= 1'b0;
    end else if (dec_refused(dec)) begin
      viol <= 1'b1;
    end else if (viol_clr) begin
      viol <= 1'b0;
    end
  end

endmodule

// File: rtl/nvwp_gate.sv
module nvwp_gate
  import nvwp_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int BLK_W   = 5,
  parameter int NUM_BLK = 2 ** (ADDR_W - BLK_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_req,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               wr_erase,
  input  logic               prot_we,
  input  logic [NUM_BLK-1:0] prot_wdata,
  input  logic               lock_we,
  input  logic               lock_wdata,
  input  logic               viol_clr,
  input  logic               lowpwr,
  input  logic               hv_override,
  output logic               pgm_stb,
  output logic [ADDR_W-1:0]  pgm_addr,
  output logic [DATA_W-1:0]  pgm_data,
  output logic               pgm_erase,
  output logic               viol,
  output logic [NUM_BLK-1:0] prot_q,
  output logic               locked_q
);

  nv_dec_e dec;

  nvwp_cfg #(.NUM_BLK(NUM_BLK)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .prot_we    (prot_we),
    .prot_wdata (prot_wdata),
    .lock_we    (lock_we),
    .lock_wdata (lock_wdata),
    .prot_q     (prot_q),
    .locked_q   (locked_q)
  );

  nvwp_qual #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .NUM_BLK(NUM_BLK)) u_qual (
    .rst         (rst),
    .wr_req      (wr_req),
    .wr_addr     (wr_addr),
    .prot_q      (prot_q),
    .lowpwr      (lowpwr),
    .hv_override (hv_override),
    .dec         (dec)
  );

  nvwp_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .dec       (dec),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_erase  (wr_erase),
    .viol_clr  (viol_clr),
    .pgm_stb   (pgm_stb),
    .pgm_addr  (pgm_addr),
    .pgm_data  (pgm_data),
    .pgm_erase (pgm_erase),
    .viol      (viol)
  );

endmodule

// File: rtl/nvwp_gate_chk.sv
module nvwp_gate_chk #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int BLK_W   = 5,
  parameter int NUM_BLK = 2 ** (ADDR_W - BLK_W)
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_req,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic               prot_we,
  input logic               lock_we,
  input logic               lock_wdata,
  input logic               viol_clr,
  input logic               lowpwr,
  input logic               hv_override,
  input logic               pgm_stb,
  input logic               viol,
  input logic [NUM_BLK-1:0] prot_q,
  input logic               locked_q
);

  logic region_bit;
  assign region_bit = prot_q[wr_addr[ADDR_W-1:BLK_W]];

  // R2 R4: a strobe only follows a request that met every condition
  assert_stb_qualified_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && pgm_stb) |->
      ($past(wr_req) && !$past(lowpwr) && ($past(hv_override) || !$past(region_bit))));

  // R3: a qualifying request produces a strobe on the next cycle
  assert_stb_follows_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !lowpwr && (hv_override || !region_bit)) |=> pgm_stb);

  // R4: low power blocks the strobe
  assert_no_stb_sleep_R4: assert property (@(posedge clk) disable iff (rst)
    lowpwr |=> !pgm_stb);

  // R5: state after a reset edge
  assert_reset_state_R5: assert property (@(posedge clk)
    $past(rst) |-> (!pgm_stb && !viol && !locked_q && (prot_q == '0)));

  // R7: locked mask cannot change
  assert_mask_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (locked_q && prot_we) |=> $stable(prot_q));

  // R8: the lock only clears through reset
  assert_lock_one_way_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> !$fell(locked_q));

  // R7: lock write of one takes effect
  assert_lock_sets_R7: assert property (@(posedge clk) disable iff (rst)
    (lock_we && lock_wdata) |=> locked_q);

  // R9: flag is sticky without a clear, and a refusal sets it
  assert_viol_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (viol && !viol_clr) |=> viol);
  assert_viol_set_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_req && lowpwr) |=> viol);

endmodule

bind nvwp_gate nvwp_gate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W), .NUM_BLK(NUM_BLK)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_req      (wr_req),
  .wr_addr     (wr_addr),
  .prot_we     (prot_we),
  .lock_we     (lock_we),
  .lock_wdata  (lock_wdata),
  .viol_clr    (viol_clr),
  .lowpwr      (lowpwr),
  .hv_override (hv_override),
  .pgm_stb     (pgm_stb),
  .viol        (viol),
  .prot_q      (prot_q),
  .locked_q    (locked_q)
);

// File: tb/nvwp_gate_test.sv
`timescale 1ns/1ps
module nvwp_gate_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_req = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wr_erase = 1'b0;
  logic       prot_we = 1'b0;
  logic [7:0] prot_wdata = '0;
  logic       lock_we = 1'b0;
  logic       lock_wdata = 1'b0;
  logic       viol_clr = 1'b0;
  logic       lowpwr = 1'b0;
  logic       hv_override = 1'b0;
  logic       pgm_stb;
  logic [7:0] pgm_addr;
  logic [7:0] pgm_data;
  logic       pgm_erase;
  logic       viol;
  logic [7:0] prot_q;
  logic       locked_q;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] arr [256];
  logic [7:0] exp_mem [256];
  logic       m_viol;
  logic [7:0] m_mask;

  always #2 clk = ~clk;

  nvwp_gate uut (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_erase(wr_erase), .prot_we(prot_we), .prot_wdata(prot_wdata),
    .lock_we(lock_we), .lock_wdata(lock_wdata), .viol_clr(viol_clr),
    .lowpwr(lowpwr), .hv_override(hv_override), .pgm_stb(pgm_stb),
    .pgm_addr(pgm_addr), .pgm_data(pgm_data), .pgm_erase(pgm_erase),
    .viol(viol), .prot_q(prot_q), .locked_q(locked_q)
  );

  // Behavioural array written by the qualified strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) arr[i] <= 8'h00;
    end else if (pgm_stb) begin
      arr[pgm_addr] <= pgm_erase ? 8'hFF : pgm_data;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    m_viol = 1'b0;
    m_mask = 8'h00;
  endtask

  task automatic set_mask(input logic [7:0] m);
    @(negedge clk);
    prot_we = 1'b1; prot_wdata = m;
    @(negedge clk);
    prot_we = 1'b0;
    m_mask = m;
    chk(prot_q == m, "R6 mask load", prot_q, m);
  endtask

  task automatic clear_flag();
    @(negedge clk);
    viol_clr = 1'b1;
    @(negedge clk);
    viol_clr = 1'b0;
    m_viol = 1'b0;
    chk(viol == 1'b0, "R9 clear", viol, 0);
  endtask

  // One request cycle; checks strobe, payload, flag and strobe drop.
  task automatic do_req(input logic [7:0] a, input logic [7:0] d, input logic e,
                        input string tag);
    logic refused;
    @(negedge clk);
    wr_req = 1'b1; wr_addr = a; wr_data = d; wr_erase = e;
    refused = lowpwr || (m_mask[a[7:5]] && !hv_override);
    @(negedge clk);
    wr_req = 1'b0;
    chk(pgm_stb == !refused, tag, pgm_stb, !refused);
    if (!refused) begin
      chk({pgm_addr, pgm_data, pgm_erase} == {a, d, e}, "R3 payload",
          {pgm_addr, pgm_data, pgm_erase}, {a, d, e});
      exp_mem[a] = e ? 8'hFF : d;
    end
    m_viol = m_viol | refused;
    chk(viol == m_viol, "R9 flag", viol, m_viol);
    @(negedge clk);
    chk(pgm_stb == 1'b0, "R3 single pulse", pgm_stb, 0);
  endtask

  task automatic cmp_array(input string tag);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (arr[i] !== exp_mem[i]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] masks [6];
    masks[0] = 8'h00; masks[1] = 8'hFF; masks[2] = 8'hA5;
    masks[3] = 8'h5A; masks[4] = 8'h01; masks[5] = 8'h80;

    do_reset();
    @(negedge clk);
    // R5: reset state
    chk({pgm_stb, viol, locked_q} == 3'b000, "R5 reset outputs",
        {pgm_stb, viol, locked_q}, 0);
    chk(prot_q == 8'h00, "R5 reset mask", prot_q, 0);

    // R1 R2 R4: sweep masks, override, low power over all addresses
    for (int m = 0; m < 6; m++) begin
      for (int ov = 0; ov < 2; ov++) begin
        for (int lp = 0; lp < 2; lp++) begin
          set_mask(masks[m]);
          clear_flag();
          @(negedge clk);
          hv_override = ov[0];
          lowpwr = lp[0];
          for (int a = 0; a < 256; a++) begin
            do_req(a[7:0], a[7:0] ^ masks[m] ^ 8'(m * 7 + ov * 3 + lp),
                   a[1] ^ ov[0], lp[0] ? "R4 sleep refusal" : "R1 R2 region gate");
          end
          cmp_array("R2 array contents");
          @(negedge clk);
          hv_override = 1'b0;
          lowpwr = 1'b0;
        end
      end
    end

    // R9: refusal and clear in the same cycle, refusal wins
    set_mask(8'h00);
    clear_flag();
    @(negedge clk);
    lowpwr = 1'b1; wr_req = 1'b1; wr_addr = 8'h10; viol_clr = 1'b1;
    @(negedge clk);
    wr_req = 1'b0; viol_clr = 1'b0; lowpwr = 1'b0;
    chk(viol == 1'b1, "R9 set beats clear", viol, 1);
    clear_flag();

    // R10: mask write in the request cycle affects only later requests
    @(negedge clk);
    prot_we = 1'b1; prot_wdata = 8'hFF;
    wr_req = 1'b1; wr_addr = 8'h00; wr_data = 8'h3C; wr_erase = 1'b0;
    @(negedge clk);
    prot_we = 1'b0; wr_req = 1'b0;
    chk(pgm_stb == 1'b1, "R10 old mask used", pgm_stb, 1);
    m_mask = 8'hFF;
    exp_mem[0] = 8'h3C;
    do_req(8'h00, 8'h11, 1'b0, "R10 new mask used");

    // R10 R7: mask written together with the lock is still taken
    @(negedge clk);
    prot_we = 1'b1; prot_wdata = 8'h3C; lock_we = 1'b1; lock_wdata = 1'b1;
    @(negedge clk);
    prot_we = 1'b0; lock_we = 1'b0;
    chk(locked_q == 1'b1, "R7 lock set", locked_q, 1);
    chk(prot_q == 8'h3C, "R10 mask with lock", prot_q, 8'h3C);
    m_mask = 8'h3C;

    // R7: locked mask write ignored, protection still enforced
    @(negedge clk);
    prot_we = 1'b1; prot_wdata = 8'h00;
    @(negedge clk);
    prot_we = 1'b0;
    chk(prot_q == 8'h3C, "R7 mask frozen", prot_q, 8'h3C);
    clear_flag();
    do_req(8'h45, 8'h77, 1'b0, "R7 locked region refused");
    do_req(8'h05, 8'h78, 1'b0, "R7 open region passes");

    // R8: writing zero to the lock has no effect
    @(negedge clk);
    lock_we = 1'b1; lock_wdata = 1'b0;
    @(negedge clk);
    lock_we = 1'b0;
    chk(locked_q == 1'b1, "R8 lock holds", locked_q, 1);

    // R5: request during reset is not accepted, reset reopens the lock
    @(negedge clk);
    rst = 1'b1; wr_req = 1'b1; wr_addr = 8'h01; wr_data = 8'h99;
    @(negedge clk);
    wr_req = 1'b0;
    chk(pgm_stb == 1'b0, "R5 no strobe in reset", pgm_stb, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(locked_q == 1'b0, "R8 reset clears lock", locked_q, 0);
    chk(prot_q == 8'h00, "R5 mask cleared", prot_q, 0);
    chk(viol == 1'b0, "R5 flag cleared", viol, 0);
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    m_viol = 1'b0; m_mask = 8'h00;
    cmp_array("R5 array untouched in reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule